// File: doc/BRIEF.md
# Interleaved Two-Port Data-Cache Bank Arbiter

This block puts two data-cache access ports in front of eight single-ported word banks. Consecutive 32-bit words are spread across the banks, so the bank an access uses is given by its word address. When the two ports address different banks in the same cycle, both accesses are carried out at once. When they address the same bank, the first port is served and the request on the second port is held inside the block and served in the following cycle. During that one cycle `req_ready` is low and new requests on both ports are not taken.

Each port carries a byte, half-word or word load or store. The block checks natural alignment, builds the byte-lane write enables, places store data on the right lanes, and returns loaded data right-aligned and zero-extended. A configuration input mirrors the lane order for big-endian operation. Special cache operations are accepted only on the second port. They take no bank cycle and are only acknowledged here; the tag and miss logic that would carry them out sits outside this block.

Top module: `bankarb_top`

## Requirements
- R1: The bank used by an access is address bits [4:2]. The row within that bank is the address bits above bit 4. A word stored at an address is returned by a later word load from the same address.
- R2: When both ports carry an accepted load or store and the two bank indices differ, both accesses complete, and `p1_done` and `p2_done` are both 1 one cycle later.
- R3: When both ports carry an accepted load or store to the same bank, port 1 is served first. `req_ready` is low for exactly the next cycle, and the held port-2 access is served in that cycle. Its `p2_done` follows one cycle after that, and it sees the result of port 1's write.
- R4: While `req_ready` is low, the inputs on both ports are ignored. They produce no response and no bank write.
- R5: Sizes must be naturally aligned. A half-word with address bit 0 set, or a word with address bits [1:0] not zero, gives an error response and makes no bank access.
- R6: The size code is 0 for a byte, 1 for a half-word and 2 for a word. Code 3 is illegal and always gives an error response.
- R7: In little-endian mode (`big_endian`=0), a byte uses lane address[1:0], where lane k is bits 8k+7..8k, and a half-word uses lanes address[1:0] and address[1:0]+1. Store data is taken from the low bits. Load data is returned right-aligned and zero-extended.
- R8: In big-endian mode, a byte uses lane 3-address[1:0] and a half-word uses lanes 2-address[1:0] and 3-address[1:0], with the value placed in those lanes without a byte swap. Words are not affected by the mode.
- R9: The kind code is 0 for a load and 1 for a store, and 2 or 3 for a special operation. A special operation on port 2 is acknowledged with `p2_done`, reads as zero and makes no bank access.
- R10: A special operation on port 1 gives `p1_err` and is not performed.
- R11: When port 2 carries a special operation, a load or store on port 1 in the same cycle is rejected with `p1_err`, and the special operation is still acknowledged.
- R12: After reset, `req_ready` is 1 and all done and error outputs are 0.
- R13: Every response (done or error, plus load data) appears exactly one cycle after the request is taken and lasts one cycle. Done and error are never both set on one port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | 1 selects mirrored (big-endian) lane order |
| p1_valid | input | 1 | Port 1 request present |
| p1_kind | input | 2 | Port 1 operation: 0 load, 1 store, 2/3 special |
| p1_size | input | 2 | Port 1 size: 0 byte, 1 half, 2 word, 3 illegal |
| p1_addr | input | ADDR_W | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 store data, right-aligned |
| p2_valid | input | 1 | Port 2 request present |
| p2_kind | input | 2 | Port 2 operation |
| p2_size | input | 2 | Port 2 size |
| p2_addr | input | ADDR_W | Port 2 byte address |
| p2_wdata | input | 32 | Port 2 store data, right-aligned |
| req_ready | output | 1 | Low for the one cycle in which a held port-2 access is served |
| p1_done | output | 1 | Port 1 access completed |
| p1_err | output | 1 | Port 1 request rejected |
| p1_rdata | output | 32 | Port 1 load data, valid with `p1_done` |
| p2_done | output | 1 | Port 2 access or special operation completed |
| p2_err | output | 1 | Port 2 request rejected |
| p2_rdata | output | 32 | Port 2 load data, valid with `p2_done` |

## Verification
A request taken at a clock edge is answered right after that edge: done, error and load data appear one cycle later. A conflicting port-2 access is answered one edge later still, and `req_ready` is low in between. The bench drives inputs on the falling edge, lets exactly one rising edge pass and then compares on the next falling edge. For conflicts it compares again after the second edge, which confirms both the hold cycle and the order of the writes. Inputs presented during the stall are checked for having no effect twice: by watching the response outputs, and by reading back the word they would have overwritten.

// File: rtl/bankarb_pkg.sv
package bankarb_pkg;
    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_SPEC_A = 2'd2,
        OP_SPEC_B = 2'd3
    } op_kind_e;
endpackage

// File: rtl/bankarb_decode.sv
module bankarb_decode
    import bankarb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BANK_BITS = 3,
    localparam int ROW_W    = ADDR_W - BANK_BITS - 2
) (
    input  logic [1:0]           size,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 big,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_W-1:0]     row,
    output logic                 misalign,
    output logic [LANES-1:0]     be,
    output logic [4:0]           shift,
    output logic [WORD_W-1:0]    mask
);
    logic [1:0] off;
    logic [1:0] lane;

    assign off  = addr[1:0];
    assign bank = addr[BANK_BITS+1:2];
    assign row  = addr[ADDR_W-1:BANK_BITS+2];

    always_comb begin
        misalign = 1'b0;
        lane     = 2'd0;
        be       = '0;
        mask     = '0;
        case (size)
            SZ_BYTE: begin
                lane = big ? ~off : off;
                be   = 4'(4'b0001 << lane);
                mask = 32'h0000_00FF;
            end
            SZ_HALF: begin
                misalign = off[0];
                lane     = big ? 2'(2'd2 - off) : off;
                be       = 4'(4'b0011 << lane);
                mask     = 32'h0000_FFFF;
            end
            SZ_WORD: begin
                misalign = (off != 2'd0);
                be       = 4'b1111;
                mask     = 32'hFFFF_FFFF;
            end
            default: misalign = 1'b1;
        endcase
        shift = {lane, 3'b000};
    end
endmodule

// File: rtl/bankarb_bank.sv
module bankarb_bank
    import bankarb_pkg::*;
#(
    parameter int ROW_W = 5,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            for (int k = 0; k < LANES; k++) begin
                if (we && be[k]) mem[row][8*k +: 8] <= wdata[8*k +: 8];
            end
            rdata <= mem[row];
        end
    end
endmodule

// File: rtl/bankarb_top.sv
module bankarb_top
    import bankarb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BANK_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              p1_valid,
    input  logic [1:0]        p1_kind,
    input  logic [1:0]        p1_size,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [31:0]       p1_wdata,
    input  logic              p2_valid,
    input  logic [1:0]        p2_kind,
    input  logic [1:0]        p2_size,
    input  logic [ADDR_W-1:0] p2_addr,
    input  logic [31:0]       p2_wdata,
    output logic              req_ready,
    output logic              p1_done,
    output logic              p1_err,
    output logic [31:0]       p1_rdata,
    output logic              p2_done,
    output logic              p2_err,
    output logic [31:0]       p2_rdata
);
    localparam int NBANKS = 1 << BANK_BITS;
    localparam int ROW_W  = ADDR_W - BANK_BITS - 2;

    typedef struct packed {
        logic                 hold;
        logic [1:0]           h_kind;
        logic [1:0]           h_size;
        logic [ADDR_W-1:0]    h_addr;
        logic [WORD_W-1:0]    h_wdata;
        logic                 r1_done;
        logic                 r1_err;
        logic                 r1_load;
        logic [BANK_BITS-1:0] r1_bank;
        logic [4:0]           r1_shift;
        logic [WORD_W-1:0]    r1_mask;
        logic                 r2_done;
        logic                 r2_err;
        logic                 r2_load;
        logic [BANK_BITS-1:0] r2_bank;
        logic [4:0]           r2_shift;
        logic [WORD_W-1:0]    r2_mask;
    } state_t;

    state_t st_d, st_q;

    // effective port-2 request: the held one wins while stalled
    logic              q2_valid;
    logic [1:0]        q2_kind, q2_size;
    logic [ADDR_W-1:0] q2_addr;
    logic [WORD_W-1:0] q2_wdata;

    assign q2_valid = st_q.hold | p2_valid;
    assign q2_kind  = st_q.hold ? st_q.h_kind  : p2_kind;
    assign q2_size  = st_q.hold ? st_q.h_size  : p2_size;
    assign q2_addr  = st_q.hold ? st_q.h_addr  : p2_addr;
    assign q2_wdata = st_q.hold ? st_q.h_wdata : p2_wdata;

    logic [BANK_BITS-1:0] d1_bank, d2_bank;
    logic [ROW_W-1:0]     d1_row, d2_row;
    logic                 d1_mis, d2_mis;
    logic [LANES-1:0]     d1_be, d2_be;
    logic [4:0]           d1_shift, d2_shift;
    logic [WORD_W-1:0]    d1_mask, d2_mask;

    bankarb_decode #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_dec1 (
        .size(p1_size), .addr(p1_addr), .big(big_endian),
        .bank(d1_bank), .row(d1_row), .misalign(d1_mis),
        .be(d1_be), .shift(d1_shift), .mask(d1_mask)
    );

    bankarb_decode #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)) u_dec2 (
        .size(q2_size), .addr(q2_addr), .big(big_endian),
        .bank(d2_bank), .row(d2_row), .misalign(d2_mis),
        .be(d2_be), .shift(d2_shift), .mask(d2_mask)
    );

    logic p1_act, p1_bad, p1_go, p1_store;
    logic q2_spec, q2_bad, q2_bank_req, q2_serve, q2_store;
    logic clash;

    always_comb begin
        p1_act      = p1_valid & ~st_q.hold;
        q2_spec     = q2_valid & q2_kind[1];
        p1_bad      = p1_act & (p1_kind[1] | d1_mis | q2_spec);
        p1_go       = p1_act & ~p1_bad;
        p1_store    = (p1_kind == OP_STORE);
        q2_bad      = q2_valid & ~q2_kind[1] & d2_mis;
        q2_bank_req = q2_valid & ~q2_kind[1] & ~d2_mis;
        clash       = p1_go & q2_bank_req & (d1_bank == d2_bank);
        q2_serve    = q2_bank_req & ~clash;
        q2_store    = (q2_kind == OP_STORE);

        st_d          = st_q;
        st_d.hold     = clash;
        st_d.h_kind   = p2_kind;
        st_d.h_size   = p2_size;
        st_d.h_addr   = p2_addr;
        st_d.h_wdata  = p2_wdata;
        st_d.r1_done  = p1_go;
        st_d.r1_err   = p1_bad;
        st_d.r1_load  = p1_go & (p1_kind == OP_LOAD);
        st_d.r1_bank  = d1_bank;
        st_d.r1_shift = d1_shift;
        st_d.r1_mask  = d1_mask;
        st_d.r2_done  = q2_serve | q2_spec;
        st_d.r2_err   = q2_bad;
        st_d.r2_load  = q2_serve & (q2_kind == OP_LOAD);
        st_d.r2_bank  = d2_bank;
        st_d.r2_shift = d2_shift;
        st_d.r2_mask  = d2_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [WORD_W-1:0] bank_rd [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic hit1, hit2;
        assign hit1 = p1_go    && (d1_bank == BANK_BITS'(b));
        assign hit2 = q2_serve && (d2_bank == BANK_BITS'(b));

        bankarb_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .en    (hit1 | hit2),
            .we    (hit1 ? p1_store : q2_store),
            .be    (hit1 ? d1_be : d2_be),
            .row   (hit1 ? d1_row : d2_row),
            .wdata (hit1 ? (p1_wdata << d1_shift) : (q2_wdata << d2_shift)),
            .rdata (bank_rd[b])
        );
    end

    assign req_ready = ~st_q.hold;
    assign p1_done   = st_q.r1_done;
    assign p1_err    = st_q.r1_err;
    assign p2_done   = st_q.r2_done;
    assign p2_err    = st_q.r2_err;
    assign p1_rdata  = st_q.r1_load ? ((bank_rd[st_q.r1_bank] >> st_q.r1_shift) & st_q.r1_mask) : '0;
    assign p2_rdata  = st_q.r2_load ? ((bank_rd[st_q.r2_bank] >> st_q.r2_shift) & st_q.r2_mask) : '0;
endmodule

// File: rtl/bankarb_chk.sv
module bankarb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       p1_valid,
    input logic [1:0] p1_kind,
    input logic [1:0] p1_size,
    input logic [1:0] p1_off,
    input logic       p1_done,
    input logic       p1_err,
    input logic       p2_done,
    input logic       p2_err
);
    // R3
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R3
    held_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> p2_done);

    // R3
    port1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> p1_done);

    // R4
    stall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !p1_done && !p1_err);

    // R10
    p1_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && p1_valid && p1_kind[1] |=> p1_err && !p1_done);

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && p1_valid && p1_size == 2'd2 && p1_off != 2'd0 |=> p1_err);

    // R13
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(p1_done && p1_err) && !(p2_done && p2_err));
endmodule

bind bankarb_top bankarb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .p1_valid  (p1_valid),
    .p1_kind   (p1_kind),
    .p1_size   (p1_size),
    .p1_off    (p1_addr[1:0]),
    .p1_done   (p1_done),
    .p1_err    (p1_err),
    .p2_done   (p2_done),
    .p2_err    (p2_err)
);

// File: tb/tb_bankarb_top.sv
module tb_bankarb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          big_endian = 1'b0;
    logic          p1_valid = 1'b0, p2_valid = 1'b0;
    logic [1:0]    p1_kind = '0, p1_size = '0, p2_kind = '0, p2_size = '0;
    logic [AW-1:0] p1_addr = '0, p2_addr = '0;
    logic [31:0]   p1_wdata = '0, p2_wdata = '0;
    logic          req_ready, p1_done, p1_err, p2_done, p2_err;
    logic [31:0]   p1_rdata, p2_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bankarb_top #(.ADDR_W(AW), .BANK_BITS(3)) dut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .p1_valid(p1_valid), .p1_kind(p1_kind), .p1_size(p1_size),
        .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p2_valid(p2_valid), .p2_kind(p2_kind), .p2_size(p2_size),
        .p2_addr(p2_addr), .p2_wdata(p2_wdata),
        .req_ready(req_ready), .p1_done(p1_done), .p1_err(p1_err),
        .p1_rdata(p1_rdata), .p2_done(p2_done), .p2_err(p2_err),
        .p2_rdata(p2_rdata)
    );

    typedef struct packed {
        logic          big;
        logic          v1;
        logic [1:0]    k1, s1;
        logic [AW-1:0] a1;
        logic [31:0]   w1;
        logic          v2;
        logic [1:0]    k2, s2;
        logic [AW-1:0] a2;
        logic [31:0]   w2;
        logic          d1, e1;
        logic [31:0]   r1;
        logic          d2, e2;
        logic [31:0]   r2;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R2 two word stores, banks 0 and 1
        '{1'b0, 1'b1, 2'd1, 2'd2, 10'h000, 32'h11223344, 1'b1, 2'd1, 2'd2, 10'h004, 32'hAABBCCDD,
          1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 4'd2},
        // R1 read both words back, crossed
        '{1'b0, 1'b1, 2'd0, 2'd2, 10'h004, 32'h0, 1'b1, 2'd0, 2'd2, 10'h000, 32'h0,
          1'b1, 1'b0, 32'hAABBCCDD, 1'b1, 1'b0, 32'h11223344, 4'd1},
        // R7 byte store lane 1, byte load lane 3 zero-extended
        '{1'b0, 1'b1, 2'd1, 2'd0, 10'h001, 32'h00000055, 1'b1, 2'd0, 2'd0, 10'h007, 32'h0,
          1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h000000AA, 4'd7},
        // R7 word load after byte merge, half store upper lanes
        '{1'b0, 1'b1, 2'd0, 2'd2, 10'h000, 32'h0, 1'b1, 2'd1, 2'd1, 10'h006, 32'h00007788,
          1'b1, 1'b0, 32'h11225544, 1'b1, 1'b0, 32'h0, 4'd7},
        // R7 half loads
        '{1'b0, 1'b1, 2'd0, 2'd1, 10'h006, 32'h0, 1'b1, 2'd0, 2'd1, 10'h000, 32'h0,
          1'b1, 1'b0, 32'h00007788, 1'b1, 1'b0, 32'h00005544, 4'd7},
        // R5 misaligned word store on port 1
        '{1'b0, 1'b1, 2'd1, 2'd2, 10'h002, 32'hDEADBEEF, 1'b1, 2'd0, 2'd2, 10'h004, 32'h0,
          1'b0, 1'b1, 32'h0, 1'b1, 1'b0, 32'h7788CCDD, 4'd5},
        // R5 word 0 untouched; misaligned half on port 2
        '{1'b0, 1'b1, 2'd0, 2'd2, 10'h000, 32'h0, 1'b1, 2'd1, 2'd1, 10'h009, 32'h0000FFFF,
          1'b1, 1'b0, 32'h11225544, 1'b0, 1'b1, 32'h0, 4'd5},
        // R6 illegal size code
        '{1'b0, 1'b1, 2'd0, 2'd3, 10'h008, 32'h0, 1'b0, 2'd0, 2'd0, 10'h000, 32'h0,
          1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 32'h0, 4'd6},
        // R10 special on port 1; R9 special on port 2
        '{1'b0, 1'b1, 2'd2, 2'd0, 10'h000, 32'h0, 1'b1, 2'd3, 2'd0, 10'h000, 32'h0,
          1'b0, 1'b1, 32'h0, 1'b1, 1'b0, 32'h0, 4'd10},
        // R11 load on port 1 beside special on port 2
        '{1'b0, 1'b1, 2'd0, 2'd2, 10'h000, 32'h0, 1'b1, 2'd2, 2'd0, 10'h040, 32'h0,
          1'b0, 1'b1, 32'h0, 1'b1, 1'b0, 32'h0, 4'd11},
        // R2 words for the big-endian tests
        '{1'b0, 1'b1, 2'd1, 2'd2, 10'h020, 32'h01020304, 1'b1, 2'd1, 2'd2, 10'h024, 32'h05060708,
          1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 4'd2},
        // R8 byte store at offset 0 -> lane 3; half load offset 0 -> lanes 2,3
        '{1'b1, 1'b1, 2'd1, 2'd0, 10'h020, 32'h000000EE, 1'b1, 2'd0, 2'd1, 10'h024, 32'h0,
          1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h00000506, 4'd8},
        // R8 word unaffected; byte offset 3 -> lane 0
        '{1'b1, 1'b1, 2'd0, 2'd2, 10'h020, 32'h0, 1'b1, 2'd0, 2'd0, 10'h027, 32'h0,
          1'b1, 1'b0, 32'hEE020304, 1'b1, 1'b0, 32'h00000008, 4'd8},
        // R8 half offset 2 -> lanes 0,1 for load and store
        '{1'b1, 1'b1, 2'd0, 2'd1, 10'h022, 32'h0, 1'b1, 2'd1, 2'd1, 10'h026, 32'h0000ABCD,
          1'b1, 1'b0, 32'h00000304, 1'b1, 1'b0, 32'h0, 4'd8},
        // R8 result of the big-endian half store
        '{1'b0, 1'b1, 2'd0, 2'd2, 10'h024, 32'h0, 1'b0, 2'd0, 2'd0, 10'h000, 32'h0,
          1'b1, 1'b0, 32'h0506ABCD, 1'b0, 1'b0, 32'h0, 4'd8}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive1(input logic v, input logic [1:0] k, input logic [1:0] s,
                          input logic [AW-1:0] a, input logic [31:0] w);
        p1_valid = v; p1_kind = k; p1_size = s; p1_addr = a; p1_wdata = w;
    endtask

    task automatic drive2(input logic v, input logic [1:0] k, input logic [1:0] s,
                          input logic [AW-1:0] a, input logic [31:0] w);
        p2_valid = v; p2_kind = k; p2_size = s; p2_addr = a; p2_wdata = w;
    endtask

    task automatic idle();
        drive1(1'b0, 2'd0, 2'd0, '0, '0);
        drive2(1'b0, 2'd0, 2'd0, '0, '0);
        big_endian = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R12", "done/err in reset", {28'b0, p1_done, p1_err, p2_done, p2_err}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R12", "idle after reset", {27'b0, req_ready, p1_done, p1_err, p2_done, p2_err}, 32'h10);

        for (int i = 0; i < NV; i++) begin
            big_endian = VECS[i].big;
            drive1(VECS[i].v1, VECS[i].k1, VECS[i].s1, VECS[i].a1, VECS[i].w1);
            drive2(VECS[i].v2, VECS[i].k2, VECS[i].s2, VECS[i].a2, VECS[i].w2);
            step();
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d p1 done/err", i),
                {30'b0, p1_done, p1_err}, {30'b0, VECS[i].d1, VECS[i].e1});
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d p2 done/err", i),
                {30'b0, p2_done, p2_err}, {30'b0, VECS[i].d2, VECS[i].e2});
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d p1 rdata", i), p1_rdata, VECS[i].r1);
            chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d p2 rdata", i), p2_rdata, VECS[i].r2);
            chk("R2", $sformatf("vec %0d ready", i), {31'b0, req_ready}, 32'd1);
        end

        // R13 responses last one cycle
        idle();
        step();
        chk("R13", "pulse ends", {28'b0, p1_done, p1_err, p2_done, p2_err}, 32'd0);

        // preload a word that a stalled request must not overwrite
        drive1(1'b1, 2'd1, 2'd2, 10'h008, 32'h12345678);
        step();

        // R3 same-bank conflict: port-1 store, port-2 load of same word
        drive1(1'b1, 2'd1, 2'd2, 10'h040, 32'hCAFEF00D);
        drive2(1'b1, 2'd0, 2'd2, 10'h040, 32'h0);
        step();
        chk("R3", "p1 served first", {31'b0, p1_done}, 32'd1);
        chk("R3", "p2 held", {31'b0, p2_done}, 32'd0);
        chk("R3", "ready low", {31'b0, req_ready}, 32'd0);
        // R4 these are presented during the stall and must be ignored
        drive1(1'b1, 2'd0, 2'd2, 10'h004, 32'h0);
        drive2(1'b1, 2'd1, 2'd2, 10'h008, 32'hBAD0BAD0);
        step();
        chk("R3", "held p2 done", {31'b0, p2_done}, 32'd1);
        chk("R3", "held p2 sees p1 write", p2_rdata, 32'hCAFEF00D);
        chk("R4", "p1 ignored in stall", {30'b0, p1_done, p1_err}, 32'd0);
        chk("R3", "ready back", {31'b0, req_ready}, 32'd1);
        idle();
        step();
        chk("R13", "held response one cycle", {31'b0, p2_done}, 32'd0);
        drive1(1'b1, 2'd0, 2'd2, 10'h008, 32'h0);
        step();
        chk("R4", "stalled store not written", p1_rdata, 32'h12345678);

        // R3 write order on same-address conflict
        drive1(1'b1, 2'd1, 2'd2, 10'h044, 32'h00000001);
        drive2(1'b1, 2'd1, 2'd2, 10'h044, 32'h00000002);
        step();
        idle();
        step();
        chk("R3", "second store done", {31'b0, p2_done}, 32'd1);
        drive1(1'b1, 2'd0, 2'd2, 10'h044, 32'h0);
        step();
        chk("R3", "port 2 write lands last", p1_rdata, 32'h00000002);

        idle();
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule